// File: doc/BRIEF.md
# Flash Page-Buffer Program/Erase Controller

This block drives a behaviourally modelled flash array through four byte-wide registers: a command/status register, a data register and a low and a high address byte. The array is split into sectors of 1 kB, and each sector is split into 64-byte pages. Software fills a 64-byte page buffer one byte at a time and can stop after any number of bytes. A single program command then writes only the filled bytes into the page that the address selects. The block can erase one byte, one page, one sector or the whole array. Each program or erase takes a fixed number of cycles, set by a parameter, and the status register reports busy for that whole time.

Any sector can be secured. After that, a read command aimed at that sector is refused. Software cannot read the array back directly to verify it. Instead the block computes a 32-bit CRC over one sector or over the whole array, and the result can be read out one byte at a time through the data register. While the block is busy it rejects every command and sets a sticky error flag.

Top module: `flc_ctrl`

## Requirements
- R1: After a synchronous reset the status register reads 0x00, every array byte reads 0xFF, no sector is secured and the page buffer holds no valid bytes.
- R2: Register select 0 is command/status, 1 is data, 2 is the low address byte and 3 is the high address byte. The working address is the two address bytes joined {high, low}, cut to the array's address width. Data and address registers can be written at any time and read back unchanged.
- R3: Command code 1 copies the data register into page-buffer slot address[5:0] and marks that slot valid. It completes without raising busy.
- R4: Command code 2 sets busy (status bit 7) for exactly PROG_CYCLES cycles, starting in the cycle after the write. When busy ends, every valid buffer slot k is written to byte k of the page at address[AW-1:6]. Bytes whose slots are not valid keep their contents, and the buffer is left with no valid slots.
- R5: Command codes 3, 4 and 5 erase the addressed byte, page or sector to 0xFF. Busy lasts exactly ERASE_CYCLES cycles, and no byte outside the target range changes.
- R6: Command code 6 holds busy for ERASE_CYCLES cycles, then sets every byte to 0xFF and removes security from every sector.
- R7: Command code 7 loads the addressed byte into the data register on the next cycle, provided the sector is not secured. It does not raise busy.
- R8: Command code 8 secures the sector at address[AW-1:10]. A later code-7 read of that sector loads 0x00 into the data register and sets status bit 5. Only a whole-array erase removes the security; a sector erase does not.
- R9: Command codes 9 (sector at address[AW-1:10]) and 10 (whole array) compute a CRC over the bytes in ascending address order. Busy lasts one cycle per byte. The CRC uses polynomial 0x04C11DB7, is shifted MSB first, starts from 0xFFFFFFFF and has no final inversion. Secured sectors are included.
- R10: Command code 11 copies byte address[1:0] of the last CRC into the data register, where 0 is bits 7:0 and 3 is bits 31:24.
- R11: A command written while busy is ignored and sets status bit 6. Any command written while idle first clears status bits 6 and 5.
- R12: Command codes 0 and 12 to 15 change nothing except that they clear status bits 6 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |

## Verification
The hardest state to reach from the ports is a second command arriving while a program is still counting down. The stimulus issues a whole-array erase two cycles after a program starts. It then checks three things: the program still completes, the erase leaves no trace, and the error flag stays set until the next command accepted while idle. A second hard case is a CRC over a secured sector. The stimulus secures a sector, shows that reads of it are refused, then runs the whole-array CRC and compares the result byte by byte with the bench's own CRC computation.

// File: rtl/flc_pkg.sv
package flc_pkg;

    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

    typedef enum logic [3:0] {
        OP_NONE   = 4'd0,
        OP_LOAD   = 4'd1,
        OP_PROG   = 4'd2,
        OP_ERB    = 4'd3,
        OP_ERP    = 4'd4,
        OP_ERS    = 4'd5,
        OP_ERA    = 4'd6,
        OP_READ   = 4'd7,
        OP_SECURE = 4'd8,
        OP_CRCS   = 4'd9,
        OP_CRCA   = 4'd10,
        OP_CRCRD  = 4'd11
    } flc_op_e;

    typedef enum logic [1:0] {
        RS_CTRL = 2'd0,
        RS_DATA = 2'd1,
        RS_ALO  = 2'd2,
        RS_AHI  = 2'd3
    } flc_reg_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_CRC
    } flc_state_e;

    typedef struct packed {
        logic       busy;
        logic       err;
        logic       denied;
        logic [4:0] zero;
    } flc_status_t;

    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        logic        fb;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            fb = r[31] ^ d[i];
            r  = {r[30:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

endpackage

// File: rtl/flc_pagebuf.sv
module flc_pagebuf
    import flc_pkg::*;
#(
    parameter int PAGE_BYTES = 64,
    parameter int OW         = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ld_en,
    input  logic [OW-1:0]           ld_idx,
    input  logic [7:0]              ld_data,
    input  logic                    clr,
    output logic [PAGE_BYTES*8-1:0] buf_data,
    output logic [PAGE_BYTES-1:0]   buf_valid
);

    logic [7:0] slot_q [PAGE_BYTES];

    always_ff @(posedge clk) begin
        if (rst)        buf_valid <= '0;
        else if (clr)   buf_valid <= '0;
        else if (ld_en) buf_valid[ld_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (ld_en) slot_q[ld_idx] <= ld_data;
    end

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_flat
        assign buf_data[g*8 +: 8] = slot_q[g];
    end

    // R3
    load_marks_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_en && !clr) |=> buf_valid[$past(ld_idx)]);

    // R4
    clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (buf_valid == '0));

endmodule

// File: rtl/flc_array.sv
module flc_array
    import flc_pkg::*;
#(
    parameter int SECTORS      = 2,
    parameter int SECTOR_BYTES = 1024,
    parameter int PAGE_BYTES   = 64,
    parameter int TOTAL        = 2048,
    parameter int AW           = 11,
    parameter int OW           = 6,
    parameter int SW           = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    go,
    input  flc_op_e                 op,
    input  logic [AW-1:0]           op_addr,
    input  logic [PAGE_BYTES*8-1:0] buf_data,
    input  logic [PAGE_BYTES-1:0]   buf_valid,
    input  logic                    sec_set,
    input  logic [AW-SW-1:0]        sec_idx,
    input  logic [AW-1:0]           rd_addr,
    output logic [7:0]              rd_data,
    output logic                    rd_secured
);

    logic [7:0]         cell_q [TOTAL];
    logic [SECTORS-1:0] lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TOTAL; i++) cell_q[i] <= 8'hFF;
        end else if (go) begin
            case (op)
                OP_PROG: for (int k = 0; k < PAGE_BYTES; k++)
                    if (buf_valid[k]) cell_q[{op_addr[AW-1:OW], OW'(k)}] <= buf_data[k*8 +: 8];
                OP_ERB:  cell_q[op_addr] <= 8'hFF;
                OP_ERP:  for (int k = 0; k < PAGE_BYTES; k++)
                    cell_q[{op_addr[AW-1:OW], OW'(k)}] <= 8'hFF;
                OP_ERS:  for (int k = 0; k < SECTOR_BYTES; k++)
                    cell_q[{op_addr[AW-1:SW], SW'(k)}] <= 8'hFF;
                OP_ERA:  for (int i = 0; i < TOTAL; i++) cell_q[i] <= 8'hFF;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                      lock_q <= '0;
        else if (go && op == OP_ERA)  lock_q <= '0;
        else if (sec_set)             lock_q[sec_idx] <= 1'b1;
    end

    assign rd_data    = cell_q[rd_addr];
    assign rd_secured = lock_q[rd_addr[AW-1:SW]];

    // R5
    byte_erase_chk: assert property (@(posedge clk) disable iff (rst)
        (go && op == OP_ERB) |=> (cell_q[$past(op_addr)] == 8'hFF));

    // R6
    unlock_all_chk: assert property (@(posedge clk) disable iff (rst)
        (go && op == OP_ERA) |=> (lock_q == '0));

endmodule

// File: rtl/flc_crc.sv
module flc_crc
    import flc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        init,
    input  logic        step,
    input  logic [7:0]  din,
    output logic [31:0] crc
);

    always_ff @(posedge clk) begin
        if (rst)       crc <= CRC_SEED;
        else if (init) crc <= CRC_SEED;
        else if (step) crc <= crc_step(crc, din);
    end

    // R9
    seed_load_chk: assert property (@(posedge clk) disable iff (rst)
        init |=> (crc == CRC_SEED));

endmodule

// File: rtl/flc_ctrl.sv
module flc_ctrl
    import flc_pkg::*;
#(
    parameter int SECTORS          = 2,
    parameter int PAGES_PER_SECTOR = 16,
    parameter int PAGE_BYTES       = 64,
    parameter int PROG_CYCLES      = 8,
    parameter int ERASE_CYCLES     = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_we,
    input  logic [1:0] reg_sel,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata
);

    localparam int SECTOR_BYTES = PAGES_PER_SECTOR * PAGE_BYTES;
    localparam int TOTAL        = SECTORS * SECTOR_BYTES;
    localparam int AW           = $clog2(TOTAL);
    localparam int OW           = $clog2(PAGE_BYTES);
    localparam int SW           = $clog2(SECTOR_BYTES);

    logic [7:0]    data_q, alo_q, ahi_q;
    logic          err_q, den_q;
    flc_state_e    state_q;
    flc_op_e       job_op_q;
    logic [AW-1:0] job_addr_q, ptr_q;
    logic [31:0]   cnt_q;

    logic [15:0]          full_addr;
    logic [AW-1:0]        cur_addr, rd_addr;
    logic                 busy, ctrl_wr, accept, arr_go, rd_secured;
    flc_op_e              op_in;
    logic [7:0]           rd_data;
    logic [31:0]          crc_val;
    logic [PAGE_BYTES*8-1:0] buf_data;
    logic [PAGE_BYTES-1:0]   buf_valid;
    flc_status_t          status;

    assign full_addr = {ahi_q, alo_q};
    assign cur_addr  = full_addr[AW-1:0];
    assign busy      = (state_q != ST_IDLE);
    assign ctrl_wr   = reg_we && (reg_sel == RS_CTRL);
    assign accept    = ctrl_wr && !busy;
    assign op_in     = flc_op_e'(reg_wdata[3:0]);
    assign arr_go    = (state_q == ST_WAIT) && (cnt_q == 32'd0);
    assign rd_addr   = (state_q == ST_CRC) ? ptr_q : cur_addr;

    flc_pagebuf #(.PAGE_BYTES(PAGE_BYTES), .OW(OW)) i_buf (
        .clk       (clk),
        .rst       (rst),
        .ld_en     (accept && op_in == OP_LOAD),
        .ld_idx    (cur_addr[OW-1:0]),
        .ld_data   (data_q),
        .clr       (arr_go && job_op_q == OP_PROG),
        .buf_data  (buf_data),
        .buf_valid (buf_valid)
    );

    flc_array #(
        .SECTORS(SECTORS), .SECTOR_BYTES(SECTOR_BYTES), .PAGE_BYTES(PAGE_BYTES),
        .TOTAL(TOTAL), .AW(AW), .OW(OW), .SW(SW)
    ) i_array (
        .clk        (clk),
        .rst        (rst),
        .go         (arr_go),
        .op         (job_op_q),
        .op_addr    (job_addr_q),
        .buf_data   (buf_data),
        .buf_valid  (buf_valid),
        .sec_set    (accept && op_in == OP_SECURE),
        .sec_idx    (cur_addr[AW-1:SW]),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .rd_secured (rd_secured)
    );

    flc_crc i_crc (
        .clk  (clk),
        .rst  (rst),
        .init (accept && (op_in == OP_CRCS || op_in == OP_CRCA)),
        .step (state_q == ST_CRC),
        .din  (rd_data),
        .crc  (crc_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q     <= '0;
            alo_q      <= '0;
            ahi_q      <= '0;
            err_q      <= 1'b0;
            den_q      <= 1'b0;
            state_q    <= ST_IDLE;
            job_op_q   <= OP_NONE;
            job_addr_q <= '0;
            ptr_q      <= '0;
            cnt_q      <= '0;
        end else begin
            if (reg_we && reg_sel == RS_DATA) data_q <= reg_wdata;
            if (reg_we && reg_sel == RS_ALO)  alo_q  <= reg_wdata;
            if (reg_we && reg_sel == RS_AHI)  ahi_q  <= reg_wdata;
            if (ctrl_wr && busy) err_q <= 1'b1;

            case (state_q)
                ST_WAIT, ST_CRC: begin
                    if (state_q == ST_CRC) ptr_q <= ptr_q + 1'b1;
                    if (cnt_q == 32'd0) state_q <= ST_IDLE;
                    else                cnt_q   <= cnt_q - 32'd1;
                end
                default: ;
            endcase

            if (accept) begin
                err_q <= 1'b0;
                den_q <= 1'b0;
                case (op_in)
                    OP_READ: begin
                        if (rd_secured) begin
                            den_q  <= 1'b1;
                            data_q <= 8'h00;
                        end else begin
                            data_q <= rd_data;
                        end
                    end
                    OP_CRCRD: data_q <= crc_val[{cur_addr[1:0], 3'b000} +: 8];
                    OP_PROG, OP_ERB, OP_ERP, OP_ERS, OP_ERA: begin
                        state_q    <= ST_WAIT;
                        job_op_q   <= op_in;
                        job_addr_q <= cur_addr;
                        cnt_q      <= (op_in == OP_PROG) ? 32'(PROG_CYCLES - 1)
                                                         : 32'(ERASE_CYCLES - 1);
                    end
                    OP_CRCS: begin
                        state_q <= ST_CRC;
                        ptr_q   <= {cur_addr[AW-1:SW], SW'(0)};
                        cnt_q   <= 32'(SECTOR_BYTES - 1);
                    end
                    OP_CRCA: begin
                        state_q <= ST_CRC;
                        ptr_q   <= '0;
                        cnt_q   <= 32'(TOTAL - 1);
                    end
                    default: ;
                endcase
            end
        end
    end

    assign status = '{busy: busy, err: err_q, denied: den_q, zero: 5'd0};

    always_comb begin
        case (flc_reg_e'(reg_sel))
            RS_CTRL: reg_rdata = status;
            RS_DATA: reg_rdata = data_q;
            RS_ALO:  reg_rdata = alo_q;
            default: reg_rdata = ahi_q;
        endcase
    end

    // R11
    busy_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && busy) |=> (err_q && job_op_q == $past(job_op_q)));

    // R8
    denied_read_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && op_in == OP_READ && rd_secured) |=> (den_q && data_q == 8'h00));

    // R7
    open_read_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && op_in == OP_READ && !rd_secured) |=> (data_q == $past(rd_data) && !den_q));

endmodule

// File: tb/test_flc_ctrl.sv
`timescale 1ns/1ps
module test_flc_ctrl;

    localparam int TOT    = 2048;
    localparam int SECB   = 1024;
    localparam int PG     = 64;
    localparam int PROG_N = 8;
    localparam int ERAS_N = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;

    int    total = 0;
    int    bad = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    flc_ctrl i_flc_ctrl (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    // behavioural reference
    logic [7:0]  m_mem [TOT];
    logic [7:0]  m_buf [PG];
    bit   [63:0] m_val;
    bit   [1:0]  m_sec;
    logic [7:0]  m_data, m_alo, m_ahi;
    bit          m_err, m_den;
    int          m_busy, m_kind, m_jaddr, m_ptr;
    logic [31:0] m_crc;
    int          ma;
    bit          was_busy;

    function automatic logic [31:0] bcrc(logic [31:0] c, logic [7:0] d);
        c = c ^ {d, 24'h0};
        repeat (8) c = c[31] ? ((c << 1) ^ 32'h04C11DB7) : (c << 1);
        return c;
    endfunction

    task automatic apply(int kind, int ja);
        case (kind)
            2: begin
                for (int k = 0; k < PG; k++)
                    if (m_val[k]) m_mem[(ja / PG) * PG + k] = m_buf[k];
                m_val = '0;
            end
            3: m_mem[ja] = 8'hFF;
            4: for (int k = 0; k < PG; k++) m_mem[(ja / PG) * PG + k] = 8'hFF;
            5: for (int k = 0; k < SECB; k++) m_mem[(ja / SECB) * SECB + k] = 8'hFF;
            6: begin
                for (int k = 0; k < TOT; k++) m_mem[k] = 8'hFF;
                m_sec = '0;
            end
            default: ;
        endcase
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < TOT; k++) m_mem[k] = 8'hFF;
            m_val = '0; m_sec = '0; m_data = 0; m_alo = 0; m_ahi = 0;
            m_err = 0; m_den = 0; m_busy = 0; m_kind = 0; m_jaddr = 0;
            m_ptr = 0; m_crc = 32'hFFFFFFFF;
        end else begin
            was_busy = (m_busy > 0);
            ma = int'({m_ahi, m_alo}) % TOT;
            if (m_busy > 0) begin
                if (m_kind >= 9) begin
                    m_crc = bcrc(m_crc, m_mem[m_ptr]);
                    m_ptr++;
                end
                m_busy--;
                if (m_busy == 0 && m_kind < 9) apply(m_kind, m_jaddr);
            end
            if (reg_we) begin
                case (reg_sel)
                    2'd1: m_data = reg_wdata;
                    2'd2: m_alo = reg_wdata;
                    2'd3: m_ahi = reg_wdata;
                    default: begin
                        if (was_busy) m_err = 1;
                        else begin
                            m_err = 0; m_den = 0;
                            case (int'(reg_wdata[3:0]))
                                1: begin m_buf[ma % PG] = m_data; m_val[ma % PG] = 1'b1; end
                                2: begin m_busy = PROG_N; m_kind = 2; m_jaddr = ma; end
                                3, 4, 5, 6: begin
                                    m_busy = ERAS_N; m_kind = int'(reg_wdata[3:0]); m_jaddr = ma;
                                end
                                7: if (m_sec[ma / SECB]) begin m_den = 1; m_data = 8'h00; end
                                   else m_data = m_mem[ma];
                                8: m_sec[ma / SECB] = 1'b1;
                                9: begin m_busy = SECB; m_kind = 9; m_ptr = (ma / SECB) * SECB; m_crc = 32'hFFFFFFFF; end
                                10: begin m_busy = TOT; m_kind = 10; m_ptr = 0; m_crc = 32'hFFFFFFFF; end
                                11: m_data = 8'(m_crc >> (8 * (ma % 4)));
                                default: ;
                            endcase
                        end
                    end
                endcase
            end
        end
    end

    function automatic logic [7:0] mread(logic [1:0] s);
        case (s)
            2'd0: return {(m_busy > 0), m_err, m_den, 5'd0};
            2'd1: return m_data;
            2'd2: return m_alo;
            default: return m_ahi;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) chk(cur_req, 32'(reg_rdata), 32'(mread(reg_sel)));
    end

    task automatic wr(logic [1:0] s, logic [7:0] v);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_sel = s; reg_wdata = v;
        @(posedge clk); #1;
        reg_we = 1'b0; reg_sel = 2'd0;
    endtask

    task automatic set_addr(int a);
        wr(2'd2, 8'(a));
        wr(2'd3, 8'(a >> 8));
    endtask

    task automatic peek(logic [1:0] s, logic [7:0] exp, string req);
        reg_sel = s;
        @(negedge clk);
        chk(req, 32'(reg_rdata), 32'(exp));
        #1 reg_sel = 2'd0;
    endtask

    task automatic read_expect(int a, logic [7:0] exp, string req);
        set_addr(a);
        wr(2'd0, 8'd7);
        peek(2'd1, exp, req);
    endtask

    task automatic load(int a, logic [7:0] v);
        set_addr(a);
        wr(2'd1, v);
        wr(2'd0, 8'd1);
    endtask

    task automatic busy_len(int exp, string req);
        int n;
        n = 0;
        @(negedge clk);
        while (reg_rdata[7] && n < 5000) begin
            n++;
            @(negedge clk);
        end
        chk(req, 32'(n), 32'(exp));
    endtask

    task automatic wait_idle();
        while (m_busy > 0) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        cur_req = "R1";
        peek(2'd0, 8'h00, "R1");
        read_expect(0, 8'hFF, "R1");
        read_expect(TOT - 1, 8'hFF, "R1");

        // R2 register access
        cur_req = "R2";
        wr(2'd2, 8'h5A); wr(2'd3, 8'hC3); wr(2'd1, 8'h96);
        peek(2'd2, 8'h5A, "R2"); peek(2'd3, 8'hC3, "R2"); peek(2'd1, 8'h96, "R2");

        // R3 / R4 partial page program
        cur_req = "R3";
        load(12'h0C0, 8'h11); load(12'h0C5, 8'h22); load(12'h0FF, 8'h33);
        peek(2'd0, 8'h00, "R3");
        cur_req = "R4";
        set_addr(12'h0C7);
        wr(2'd0, 8'd2);
        busy_len(PROG_N, "R4");
        read_expect(12'h0C0, 8'h11, "R4"); read_expect(12'h0C5, 8'h22, "R4");
        read_expect(12'h0FF, 8'h33, "R4"); read_expect(12'h0C6, 8'hFF, "R4");
        load(12'h0C5, 8'h44);
        wr(2'd0, 8'd2); wait_idle();
        read_expect(12'h0C0, 8'h11, "R4"); read_expect(12'h0C5, 8'h44, "R4");

        // R11 command while busy
        cur_req = "R11";
        load(12'h0C1, 8'h55);
        wr(2'd0, 8'd2);
        wr(2'd0, 8'd6);
        peek(2'd0, 8'hC0, "R11");
        wait_idle();
        peek(2'd0, 8'h40, "R11");
        read_expect(12'h0C1, 8'h55, "R11");
        peek(2'd0, 8'h00, "R11");

        // R5 byte / page / sector erase
        cur_req = "R5";
        load(12'h100, 8'h77); wr(2'd0, 8'd2); wait_idle();
        load(12'h400, 8'h88); wr(2'd0, 8'd2); wait_idle();
        set_addr(12'h0C5); wr(2'd0, 8'd3);
        busy_len(ERAS_N, "R5");
        read_expect(12'h0C5, 8'hFF, "R5"); read_expect(12'h0C0, 8'h11, "R5");
        set_addr(12'h0C3); wr(2'd0, 8'd4); wait_idle();
        read_expect(12'h0C0, 8'hFF, "R5"); read_expect(12'h0C1, 8'hFF, "R5");
        read_expect(12'h100, 8'h77, "R5");
        set_addr(12'h010); wr(2'd0, 8'd5); wait_idle();
        read_expect(12'h100, 8'hFF, "R5"); read_expect(12'h400, 8'h88, "R5");

        // R7 / R8 security
        cur_req = "R8";
        set_addr(12'h400); wr(2'd0, 8'd8);
        read_expect(12'h400, 8'h00, "R8");
        peek(2'd0, 8'h20, "R8");
        cur_req = "R7";
        read_expect(12'h3FF, 8'hFF, "R7");
        peek(2'd0, 8'h00, "R7");
        cur_req = "R8";
        set_addr(12'h400); wr(2'd0, 8'd5); wait_idle();
        read_expect(12'h400, 8'h00, "R8");

        // R9 / R10 CRC
        cur_req = "R9";
        load(12'h000, 8'h12); load(12'h001, 8'h34); wr(2'd0, 8'd2); wait_idle();
        load(12'h3C0, 8'h56); wr(2'd0, 8'd2); wait_idle();
        set_addr(12'h000); wr(2'd0, 8'd9);
        busy_len(SECB, "R9");
        cur_req = "R10";
        for (int b = 0; b < 4; b++) begin
            set_addr(b); wr(2'd0, 8'd11);
            peek(2'd1, 8'(m_crc >> (8 * b)), "R10");
        end
        cur_req = "R9";
        load(12'h7FF, 8'h9A); wr(2'd0, 8'd2); wait_idle();
        set_addr(12'h404); wr(2'd0, 8'd8);
        wr(2'd0, 8'd10);
        busy_len(TOT, "R9");
        cur_req = "R10";
        for (int b = 0; b < 4; b++) begin
            set_addr(b); wr(2'd0, 8'd11);
            peek(2'd1, 8'(m_crc >> (8 * b)), "R10");
        end

        // R6 whole-array erase
        cur_req = "R6";
        wr(2'd0, 8'd6);
        busy_len(ERAS_N, "R6");
        read_expect(12'h000, 8'hFF, "R6"); read_expect(12'h400, 8'hFF, "R6");
        peek(2'd0, 8'h00, "R6");

        // R12 unused codes
        cur_req = "R12";
        wr(2'd1, 8'h99);
        wr(2'd0, 8'd13);
        peek(2'd1, 8'h99, "R12"); peek(2'd0, 8'h00, "R12");
        load(12'h000, 8'h01); wr(2'd0, 8'd2); wr(2'd0, 8'd3); wait_idle();
        peek(2'd0, 8'h40, "R12");
        wr(2'd0, 8'd0);
        peek(2'd0, 8'h00, "R12");
        read_expect(12'h000, 8'h01, "R12");

        repeat (3) @(posedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule